// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block produces the SCL waveform of an I2C controller. It uses two programmable periods, one for the low phase and one for the high phase. Each period is nine bits wide: eight bits come from a byte input and the ninth from a separate extension input. A count advances on a tick. The tick occurs on every input clock, or on every second input clock when half-rate counting is selected.

The low phase counts from the cycle the block starts pulling SCL low, so the fall time of the line is counted inside it. The high phase counts only once the synchronised SCL input has been seen to rise. Rise time and any clock stretching by a slave therefore lengthen the bus period without eating into the programmed high time. Three one-cycle strobes tell the neighbouring byte engine when to act. The change strobe marks the point at which SDA may be updated. The sample strobe marks the point at which SDA should be read. The fall strobe marks the end of each high phase. The byte engine can also hold SCL low at the end of a low phase.

Top module: `scl_period_gen`

## Requirements
- R1: While `enable` is low, and after reset, `sclDriveLow`, `fallStrobe`, `sampleStrobe` and `changeStrobe` are all 0.
- R2: In the first cycle after the clock edge that samples `enable` high from the disabled state, `sclDriveLow` is 1.
- R3: The low phase lasts exactly effL×D cycles, whatever `sclIn` does. Here effL = max(L,1), L is the low count and D is 1 at full rate.
- R4: After the low phase, SCL stays released and the high count does not start for as long as `sclIn` stays low. No strobe fires in that time.
- R5: `sclDriveLow` returns to 1 exactly SYNC_STAGES + effH×D clock edges after the `sclIn` rise is set up, where effH = max(H,1).
- R6: With `halfRate` = 1, D = 2: every phase length and strobe offset doubles.
- R7: With HAS_EXT = 1, the count is {ext, byte}, so an ext bit of 1 adds 256 to the count.
- R8: With HAS_EXT = 0, the ext inputs have no effect and each count is the byte alone.
- R9: `fallStrobe` is 1 in the first cycle of every low phase that follows a high phase.
- R10: `sampleStrobe` pulses SYNC_STAGES + ceil(effH/2)×D edges after the `sclIn` rise.
- R11: `changeStrobe` pulses D cycles into each low phase, which is the first tick of that phase.
- R12: If `holdReq` is high when the low count expires, SCL stays low for as long as `holdReq` stays high. SCL is released on the first edge that samples `holdReq` low.
- R13: Dropping `enable` in mid-period releases SCL on the next edge and clears both counters. A later enable gives a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low releases SCL and clears counters |
| halfRate | input | 1 | 1: count tick every second clock; 0: every clock |
| lowByte | input | BYTE_W | Low-phase count, lower bits |
| lowExt | input | 1 | Low-phase count, top bit (used when HAS_EXT = 1) |
| highByte | input | BYTE_W | High-phase count, lower bits |
| highExt | input | 1 | High-phase count, top bit (used when HAS_EXT = 1) |
| holdReq | input | 1 | Keeps SCL low once the low count has expired |
| sclIn | input | 1 | Sensed SCL line level (asynchronous) |
| sclDriveLow | output | 1 | Open-drain enable: 1 pulls SCL low |
| fallStrobe | output | 1 | One-cycle pulse at the end of a high phase |
| sampleStrobe | output | 1 | One-cycle pulse in the middle of a high phase |
| changeStrobe | output | 1 | One-cycle pulse one tick into a low phase |

## Verification
The bench sweeps low and high counts at both tick rates, with and without stretching, and measures every phase and strobe offset in clock edges. Count values of 0 and 1 are targeted. A design that failed to clamp a zero count would hang in a phase. With a count of 1 at full rate, the change strobe and the phase exit fall in the same cycle, so any off-by-one in the compare logic lengthens or truncates the phase. A line held low after release catches a design that counts rise time or stretch time into the high phase; such a design would pull SCL low too early. Ext-bit runs with both variants, the hold release, and a disable in the middle of a high phase catch, in turn, a dropped ninth bit, a lost hold, and counters left stale across a restart.

// File: rtl/scl_period_pkg.sv
package scl_period_pkg;

  // Bus phase as seen by the generator.
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } sclPhase_e;

  // Control to datapath.
  typedef struct packed {
    logic clrCnt;
    logic tick;
    logic inLow;
    logic inHigh;
  } cntCtl_t;

  // Datapath to control.
  typedef struct packed {
    logic lowDone;
    logic lowFirst;
    logic highDone;
    logic highMid;
  } cntSts_t;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  output logic sclRise
);

  localparam int LAST = (STAGES < 2) ? 1 : STAGES - 1;

  logic [LAST:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[LAST-1:0], sclIn};
  end

  // A rising edge between the last two stages: the line has really come up.
  assign sclRise = syncQ[LAST-1] & ~syncQ[LAST];

endmodule

// File: rtl/scl_count_path.sv
module scl_count_path
  import scl_period_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] lowByte,
  input  logic              lowExt,
  input  logic [BYTE_W-1:0] highByte,
  input  logic              highExt,
  input  cntCtl_t           ctl,
  output cntSts_t           sts
);

  localparam int CNT_W = BYTE_W + 1;

  logic [CNT_W-1:0] lowTarget, highTarget;
  logic [CNT_W-1:0] effLow, effHigh, halfHigh;
  logic [CNT_W-1:0] lowCnt, highCnt;
  logic [CNT_W:0]   lowNextCnt, highNextCnt;

  generate
    if (HAS_EXT) begin : g_ext
      assign lowTarget  = {lowExt, lowByte};
      assign highTarget = {highExt, highByte};
    end else begin : g_noext
      assign lowTarget  = {lowExt & 1'b0, lowByte};
      assign highTarget = {highExt & 1'b0, highByte};
    end
  endgenerate

  // A zero count behaves as one tick.
  assign effLow   = (lowTarget == '0)  ? CNT_W'(1) : lowTarget;
  assign effHigh  = (highTarget == '0) ? CNT_W'(1) : highTarget;
  assign halfHigh = {1'b0, effHigh[CNT_W-1:1]} + {{(CNT_W-1){1'b0}}, effHigh[0]};

  assign lowNextCnt  = {1'b0, lowCnt}  + (CNT_W+1)'(1);
  assign highNextCnt = {1'b0, highCnt} + (CNT_W+1)'(1);

  always_comb begin
    sts.lowDone  = ctl.inLow &&
                   ((lowCnt >= effLow) || (ctl.tick && (lowNextCnt >= {1'b0, effLow})));
    sts.lowFirst = ctl.inLow && ctl.tick && (lowCnt == '0);
    sts.highDone = ctl.inHigh && ctl.tick && (highNextCnt >= {1'b0, effHigh});
    sts.highMid  = ctl.inHigh && ctl.tick && (highNextCnt == {1'b0, halfHigh});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else if (ctl.clrCnt) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else begin
      if (sts.lowDone)                    lowCnt <= effLow;   // frozen at terminal
      else if (ctl.inLow && ctl.tick)     lowCnt <= lowNextCnt[CNT_W-1:0];
      if (ctl.inHigh && ctl.tick && !sts.highDone)
        highCnt <= highNextCnt[CNT_W-1:0];
    end
  end

  AST_HIGH_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.inHigh) |-> (highCnt == '0)); // R5

  AST_LOW_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.inLow) |-> (lowCnt == '0)); // R13

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_period_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    halfRate,
  input  logic    holdReq,
  input  logic    sclRise,
  input  cntSts_t sts,
  output cntCtl_t ctl,
  output logic    sclDriveLow,
  output logic    fallStrobe,
  output logic    sampleStrobe,
  output logic    changeStrobe
);

  sclPhase_e phase, phaseNext;
  logic      psc;
  logic      phaseChange;

  always_comb begin
    phaseNext = phase;
    if (!enable) begin
      phaseNext = PH_OFF;
    end else begin
      case (phase)
        PH_OFF:  phaseNext = PH_LOW;
        PH_LOW:  if (sts.lowDone && !holdReq) phaseNext = PH_RISE;
        PH_RISE: if (sclRise) phaseNext = PH_HIGH;
        PH_HIGH: if (sts.highDone) phaseNext = PH_LOW;
        default: phaseNext = PH_OFF;
      endcase
    end
  end

  assign phaseChange = (phaseNext != phase);

  always_comb begin
    ctl.clrCnt = phaseChange || (phase == PH_OFF);
    ctl.tick   = halfRate ? psc : 1'b1;
    ctl.inLow  = (phase == PH_LOW);
    ctl.inHigh = (phase == PH_HIGH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase        <= PH_OFF;
      psc          <= 1'b0;
      sclDriveLow  <= 1'b0;
      fallStrobe   <= 1'b0;
      sampleStrobe <= 1'b0;
      changeStrobe <= 1'b0;
    end else begin
      phase        <= phaseNext;
      psc          <= (phaseChange || (phase == PH_OFF)) ? 1'b0 : ~psc;
      sclDriveLow  <= (phaseNext == PH_LOW);
      fallStrobe   <= enable && (phase == PH_HIGH) && (phaseNext == PH_LOW);
      sampleStrobe <= enable && sts.highMid;
      changeStrobe <= enable && sts.lowFirst;
    end
  end

  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !fallStrobe && !sampleStrobe && !changeStrobe)); // R1

  AST_START_PULLS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OFF && enable) |=> sclDriveLow); // R2

  AST_WAIT_FOR_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RISE && !sclRise) |=> !sclDriveLow); // R4

  AST_HOLD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (enable && holdReq && sclDriveLow) |=> sclDriveLow); // R12

  AST_FALL_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |-> sclDriveLow); // R9

  AST_EDGE_STROBES_APART: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fallStrobe, changeStrobe})); // R11

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_period_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter bit HAS_EXT     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              halfRate,
  input  logic [BYTE_W-1:0] lowByte,
  input  logic              lowExt,
  input  logic [BYTE_W-1:0] highByte,
  input  logic              highExt,
  input  logic              holdReq,
  input  logic              sclIn,
  output logic              sclDriveLow,
  output logic              fallStrobe,
  output logic              sampleStrobe,
  output logic              changeStrobe
);

  cntCtl_t ctl;
  cntSts_t sts;
  logic    sclRise;

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sclRise (sclRise)
  );

  scl_count_path #(.BYTE_W(BYTE_W), .HAS_EXT(HAS_EXT)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .lowByte  (lowByte),
    .lowExt   (lowExt),
    .highByte (highByte),
    .highExt  (highExt),
    .ctl      (ctl),
    .sts      (sts)
  );

  scl_phase_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .halfRate     (halfRate),
    .holdReq      (holdReq),
    .sclRise      (sclRise),
    .sts          (sts),
    .ctl          (ctl),
    .sclDriveLow  (sclDriveLow),
    .fallStrobe   (fallStrobe),
    .sampleStrobe (sampleStrobe),
    .changeStrobe (changeStrobe)
  );

endmodule

// File: tb/scl_period_gen_bench.sv
module scl_period_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, halfRate = 1'b0, holdReq = 1'b0, sclIn = 1'b1;
  logic lowExt = 1'b0, highExt = 1'b0;
  logic [7:0] lowByte = 8'd3, highByte = 8'd3;
  logic drv, fall, samp, chg;
  logic nEnable = 1'b0;
  logic nDrv, nFall, nSamp, nChg, nScl;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_period_gen u_scl_period_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .halfRate(halfRate),
    .lowByte(lowByte), .lowExt(lowExt), .highByte(highByte), .highExt(highExt),
    .holdReq(holdReq), .sclIn(sclIn), .sclDriveLow(drv), .fallStrobe(fall),
    .sampleStrobe(samp), .changeStrobe(chg));

  // Variant without the extension bit, on an ideal line.
  assign nScl = ~nDrv;
  scl_period_gen #(.HAS_EXT(1'b0)) u_scl_period_gen_narrow (
    .clk(clk), .rstN(rstN), .enable(nEnable), .halfRate(halfRate),
    .lowByte(lowByte), .lowExt(lowExt), .highByte(highByte), .highExt(highExt),
    .holdReq(1'b0), .sclIn(nScl), .sclDriveLow(nDrv), .fallStrobe(nFall),
    .sampleStrobe(nSamp), .changeStrobe(nChg));

  task automatic check(string req, int actual, int expected, string what);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  function automatic int effOf(int b, int e);
    int v = e * 256 + b;
    return (v == 0) ? 1 : v;
  endfunction

  // Precondition: at a negedge where drv was just seen 1.
  task automatic lowPart(int expLow, int dv, string tag);
    int k = 0;
    int kc = 0;
    do begin
      @(negedge clk);
      k++;
      if (chg && kc == 0) kc = k;
    end while (drv);
    check(tag, k, expLow * dv, "low phase cycles");
    check("R11", kc, dv, "change strobe offset");
  endtask

  task automatic highPart(int stretch, int expHigh, int dv, string tag);
    int bad = 0;
    int m = 0;
    int ms = 0;
    for (int i = 0; i < stretch; i++) begin
      @(negedge clk);
      if (drv || samp) bad++;
    end
    if (stretch > 0) check("R4", bad, 0, "activity while line held low");
    sclIn = 1'b1;
    do begin
      @(negedge clk);
      m++;
      if (samp && ms == 0) ms = m;
    end while (!drv);
    sclIn = 1'b0;
    check(tag, m, SYNC + expHigh * dv, "edges from rise to pull-down");
    check("R10", ms, SYNC + ((expHigh + 1) / 2) * dv, "sample strobe offset");
    check("R9", int'(fall), 1, "fall strobe at low entry");
  endtask

  task automatic runOne(int lb, int le, int hb, int he, int half, int stretch,
                        string lowTag, string highTag);
    lowByte  = 8'(lb);
    lowExt   = le[0];
    highByte = 8'(hb);
    highExt  = he[0];
    halfRate = half[0];
    lowPart(effOf(lb, le), half ? 2 : 1, lowTag);
    highPart(stretch, effOf(hb, he), half ? 2 : 1, highTag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
    summary();
  end

  initial begin
    int lv[4] = '{1, 2, 3, 5};
    int hv[4] = '{1, 2, 4, 7};
    int bad;
    int k;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", int'({drv, fall, samp, chg}), 0, "outputs in reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'({drv, fall, samp, chg}), 0, "outputs while disabled");

    // R2: start
    enable = 1'b1;
    @(negedge clk);
    check("R2", int'(drv), 1, "pull-down after enable");
    sclIn = 1'b0;

    // R3 R5 R6 R4: sweep
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 2; s++)
        for (int li = 0; li < 4; li++)
          for (int hi = 0; hi < 4; hi++)
            runOne(lv[li], 0, hv[hi], 0, h, s * 3,
                   h ? "R6" : "R3", h ? "R6" : "R5");

    // R3: zero counts act as one tick
    runOne(0, 0, 0, 0, 0, 0, "R3", "R5");
    runOne(0, 0, 0, 0, 1, 1, "R6", "R6");

    // R7: ninth bit
    runOne(5, 1, 2, 1, 0, 2, "R7", "R7");

    // R12: hold past the terminal count
    lowByte = 8'd4; lowExt = 1'b0; highByte = 8'd3; highExt = 1'b0; halfRate = 1'b0;
    holdReq = 1'b1;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!drv) bad++;
    end
    check("R12", bad, 0, "cycles released while held");
    holdReq = 1'b0;
    @(negedge clk);
    check("R12", int'(drv), 0, "release one edge after hold drops");
    highPart(0, 3, 1, "R5");

    // R13: disable in mid high phase
    lowPart(4, 1, "R3");
    sclIn = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R13", int'({drv, fall, samp, chg}), 0, "outputs after disable");
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (drv || fall || samp || chg) bad++;
    end
    check("R1", bad, 0, "activity while disabled");
    enable = 1'b1;
    @(negedge clk);
    check("R13", int'(drv), 1, "pull-down after re-enable");
    sclIn = 1'b0;
    runOne(6, 0, 4, 0, 0, 0, "R13", "R5");

    // R8: variant without ext bit ignores it
    enable = 1'b0;
    lowByte = 8'd5; lowExt = 1'b1; highByte = 8'd3; highExt = 1'b1; halfRate = 1'b0;
    @(negedge clk);
    nEnable = 1'b1;
    @(negedge clk);
    check("R8", int'(nDrv), 1, "narrow pull-down after enable");
    k = 0;
    do begin @(negedge clk); k++; end while (nDrv);
    check("R8", k, 5, "narrow low phase ignores ext bit");
    k = 0;
    do begin @(negedge clk); k++; end while (!nDrv);
    check("R8", k, SYNC + 3, "narrow high phase ignores ext bit");
    nEnable = 1'b0;
    @(negedge clk);

    summary();
  end

endmodule